// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects eleven interrupt sources and a core reset request and presents one request to a processor core. The request carries a vector index. Each source has a fixed slot, and the lowest index wins. Index 0 is reserved for the core reset request, and indices 1 to 11 map to source slots 0 to 10. When nothing is pending, the index reads all ones.

There are six external pins, all active low and asynchronous. Each pin passes through a two-flop synchronizer. A pin is then used in one of three ways:
- level: pending while the pin is low, with nothing stored;
- edge: a falling edge sets a latched pending bit;
- programmable: a select bit chooses level or edge.

There are seven internal sources: power-down, serial port 0 transmit and receive, byte DMA, serial port 1 transmit and receive, and timer. Each internal source is a one-cycle active-high pulse that sets a latched bit. An alternate-function mode takes away the two serial port 1 slots from the internal pulses and gives them to two programmable pins.

Software has two controls over the latched bits: a set vector and a clear vector. Every slot has a mask bit, and a global enable also gates the slots. The power-down slot and the core reset request ignore both the masks and the global enable. The core acknowledges an interrupt by index, which clears that slot's latched bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After rst_ni is released, req_o is 0 and idx_o is 4'hF (the idle code). The mask register is all zeros, so a pulse on a maskable source does not raise req_o. Whenever req_o is 0, idx_o reads 4'hF.
- R2: While core_rst_i is 1, req_o is 1 and idx_o is 0, whatever is pending, masked or enabled.
- R3: When core_rst_i is 0 and several slots are valid, idx_o is 1 plus the lowest valid slot number. Slot s maps to index s+1.
- R4: A maskable slot (slots 1 to 10) is valid only when its mask bit is 1 and glob_en_i is 1. Slot 0 (power-down, int_pulse_i bit 0) is valid whenever it is pending, whatever its mask bit and glob_en_i.
- R5: Fixed-level pins use ext_n_i bit 1 (slot 2, index 3) and bit 2 (slot 3, index 4). Such a slot is pending while its pin is low, starting two clock edges after the pin falls and ending two edges after it rises. An acknowledge does not remove the request while the pin stays low.
- R6: The fixed-edge pin is ext_n_i bit 3 (slot 6, index 7). A falling edge sets the pending bit on the third clock edge after the pin falls. The bit stays set after the pin rises. Holding the pin low does not set the bit again.
- R7: Programmable pin ext_n_i bit 0 feeds slot 1 (index 2). When edge_sel_i bit 0 is 1, the pin behaves as in R6. When it is 0, the pin behaves as in R5.
- R8: Slots 8 and 9 (indices 9 and 10) take their source from alt_mode_i. With alt_mode_i=0 they take int_pulse_i bits 4 and 5, and ext_n_i bits 4 and 5 have no effect. With alt_mode_i=1 they take ext_n_i bits 4 and 5, programmable through edge_sel_i bits 1 and 2, and int_pulse_i bits 4 and 5 have no effect.
- R9: A pulse on int_pulse_i sets its slot's latched bit at the clock edge where the pulse is sampled. The slots are: bit 0 to slot 0, bit 1 to slot 4, bit 2 to slot 5, bit 3 to slot 7, bit 6 to slot 10.
- R10: A cycle with ack_i=1 and ack_idx_i in 1..11 clears the latched bit of slot ack_idx_i-1. An ack_idx_i of 0 or above 11 changes nothing.
- R11: A 1 in sw_set_i bit s sets latched bit s, and a 1 in sw_clr_i bit s clears it. When a set and a clear reach the same bit in the same cycle, the set wins.
- R12: A cycle with mask_we_i=1 loads mask_d_i into the mask register. Bit s enables slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 6 | External request pins, active low, asynchronous |
| int_pulse_i | input | 7 | Internal one-cycle request pulses |
| alt_mode_i | input | 1 | Gives slots 8 and 9 to ext_n_i bits 4 and 5 |
| edge_sel_i | input | 3 | Edge (1) or level (0) for the programmable pins |
| glob_en_i | input | 1 | Global enable for the maskable slots |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_d_i | input | 11 | Mask write data, 1 enables the slot |
| sw_set_i | input | 11 | Software set of latched bits |
| sw_clr_i | input | 11 | Software clear of latched bits |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_idx_i | input | 4 | Index being acknowledged |
| core_rst_i | input | 1 | Core reset request, highest priority |
| req_o | output | 1 | Request to the core |
| idx_o | output | 4 | Vector index, 4'hF when idle |

## Verification
The assertions assume three things about the inputs:
- int_pulse_i, sw_set_i, sw_clr_i, mask_we_i, ack_i and core_rst_i are synchronous to clk_i;
- ack_idx_i is only read when ack_i is high;
- only the ext_n_i pins arrive asynchronously.

The bench changes every input only on the falling clock edge. It holds each pin level for several cycles, so the synchronizer latency it counts (two edges for a level, three for an edge) is exact. Alt mode and the edge selects change only while the affected pins are high, so no switch creates a falling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC = 11;
  localparam int NEXT = 6;
  localparam int NINT = 7;
  localparam int NSEL = 3;
  localparam int IDXW = $clog2(NSRC + 1);

  typedef enum logic [2:0] {SK_INT, SK_LVL, SK_EDG, SK_PRG, SK_ALT} src_kind_e;

  function automatic src_kind_e slot_kind(input int s);
    case (s)
      0, 4, 5, 7, 10: return SK_INT;
      2, 3:           return SK_LVL;
      6:              return SK_EDG;
      1:              return SK_PRG;
      default:        return SK_ALT;
    endcase
  endfunction

  function automatic int slot_ext(input int s);
    case (s)
      1: return 0;
      2: return 1;
      3: return 2;
      6: return 3;
      8: return 4;
      9: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int slot_int(input int s);
    case (s)
      4:  return 1;
      5:  return 2;
      7:  return 3;
      8:  return 4;
      9:  return 5;
      10: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int slot_sel(input int s);
    case (s)
      8: return 1;
      9: return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/prio_irq_pin.sv
module prio_irq_pin #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_n_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] low_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pin_n_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall_o = prev_q & ~s2_q;
  assign low_o  = ~s2_q;
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lat_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] lat_q;

  // set dominates so an event arriving with its own ack is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= (lat_q & ~clr_i) | set_i;
  end

  assign lat_o  = lat_q;
  assign pend_o = lat_q | lvl_i;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N    = 11,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    valid_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int s = N - 1; s >= 0; s--) begin
      if (valid_i[s]) idx_o = IDXW'(s + 1);
    end
  end

  assign any_o = |valid_i;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NS = prio_irq_pkg::NSRC,
  parameter int NE = prio_irq_pkg::NEXT,
  parameter int NI = prio_irq_pkg::NINT,
  parameter int NL = prio_irq_pkg::NSEL,
  parameter int IW = prio_irq_pkg::IDXW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NE-1:0] ext_n_i,
  input  logic [NI-1:0] int_pulse_i,
  input  logic          alt_mode_i,
  input  logic [NL-1:0] edge_sel_i,
  input  logic          glob_en_i,
  input  logic          mask_we_i,
  input  logic [NS-1:0] mask_d_i,
  input  logic [NS-1:0] sw_set_i,
  input  logic [NS-1:0] sw_clr_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_idx_i,
  input  logic          core_rst_i,
  output logic          req_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [NS-1:0] NMI_SLOTS = NS'(1);
  localparam logic [IW-1:0] MAX_IDX   = IW'(NS);

  logic [NE-1:0] fall, low;
  logic [NS-1:0] evt_set, lvl, set_v, clr_v, ack_oh;
  logic [NS-1:0] lat_q, pend, valid, mask_q;
  logic          arb_any;
  logic [IW-1:0] arb_idx;

  prio_irq_pin #(.W(NE)) i_pin (
    .clk_i, .rst_ni, .pin_n_i(ext_n_i), .fall_o(fall), .low_o(low)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam src_kind_e K = slot_kind(s);
    localparam int XB = slot_ext(s);
    localparam int IB = slot_int(s);
    localparam int SB = slot_sel(s);
    if (K == SK_INT) begin : g_int
      assign evt_set[s] = int_pulse_i[IB];
      assign lvl[s]     = 1'b0;
    end else if (K == SK_LVL) begin : g_lvl
      assign evt_set[s] = 1'b0;
      assign lvl[s]     = low[XB];
    end else if (K == SK_EDG) begin : g_edg
      assign evt_set[s] = fall[XB];
      assign lvl[s]     = 1'b0;
    end else if (K == SK_PRG) begin : g_prg
      assign evt_set[s] = edge_sel_i[SB] & fall[XB];
      assign lvl[s]     = ~edge_sel_i[SB] & low[XB];
    end else begin : g_alt
      assign evt_set[s] = alt_mode_i ? (edge_sel_i[SB] & fall[XB]) : int_pulse_i[IB];
      assign lvl[s]     = alt_mode_i & ~edge_sel_i[SB] & low[XB];
    end
  end

  always_comb begin
    ack_oh = '0;
    if (ack_i && ack_idx_i != '0 && ack_idx_i <= MAX_IDX)
      ack_oh = NS'(1) << (ack_idx_i - 1'b1);
  end

  assign set_v = evt_set | sw_set_i;
  assign clr_v = ack_oh | sw_clr_i;

  prio_irq_pend #(.N(NS)) i_pend (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .lvl_i(lvl),
    .lat_o(lat_q), .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign valid = pend & (NMI_SLOTS | (mask_q & {NS{glob_en_i}}));

  prio_irq_arb #(.N(NS), .IDXW(IW)) i_arb (
    .valid_i(valid), .any_o(arb_any), .idx_o(arb_idx)
  );

  assign req_o = core_rst_i | arb_any;
  assign idx_o = core_rst_i ? '0 : arb_idx;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NS = 11,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          core_rst_i,
  input logic          glob_en_i,
  input logic          ack_i,
  input logic [IW-1:0] ack_idx_i,
  input logic [NS-1:0] sw_set_i,
  input logic [NS-1:0] set_v,
  input logic [NS-1:0] lat_q,
  input logic [NS-1:0] mask_q,
  input logic          req_o,
  input logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] IDLE    = '1;
  localparam logic [IW-1:0] MAX_IDX = IW'(NS);

  p_idle_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> idx_o == IDLE);

  p_core_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_i |-> (req_o && idx_o == '0));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> idx_o <= MAX_IDX);

  p_nmi_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_i && !glob_en_i && req_o) |-> idx_o == IW'(1));

  p_lvl_no_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lat_q[2]) |-> $past(sw_set_i[2]));

  p_ack_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_idx_i != '0 && ack_idx_i <= MAX_IDX && !set_v[ack_idx_i - 1'b1])
      |=> !lat_q[$past(ack_idx_i) - 1'b1]);

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i != '0) |=> ((lat_q & $past(sw_set_i)) == $past(sw_set_i)));

  p_mask_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_i && req_o && idx_o > IW'(1)) |-> mask_q[idx_o - 1'b1]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NS(NS), .IW(IW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .core_rst_i(core_rst_i), .glob_en_i(glob_en_i),
  .ack_i(ack_i), .ack_idx_i(ack_idx_i), .sw_set_i(sw_set_i), .set_v(set_v),
  .lat_q(lat_q), .mask_q(mask_q), .req_o(req_o), .idx_o(idx_o)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  ext_n_i = 6'h3F;
  logic [6:0]  int_pulse_i = '0;
  logic        alt_mode_i = 1'b0;
  logic [2:0]  edge_sel_i = '0;
  logic        glob_en_i = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [10:0] mask_d_i = '0;
  logic [10:0] sw_set_i = '0;
  logic [10:0] sw_clr_i = '0;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_idx_i = '0;
  logic        core_rst_i = 1'b0;
  logic        req_o;
  logic [3:0]  idx_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni, .ext_n_i, .int_pulse_i, .alt_mode_i, .edge_sel_i,
    .glob_en_i, .mask_we_i, .mask_d_i, .sw_set_i, .sw_clr_i, .ack_i,
    .ack_idx_i, .core_rst_i, .req_o, .idx_o
  );

  task automatic chk(input string rid, input logic er, input logic [3:0] ei);
    n_chk++;
    if (req_o !== er || idx_o !== ei) begin
      n_bad++;
      $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d", rid, req_o, idx_o, er, ei);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_int(input int b);
    int_pulse_i[b] = 1'b1;
    tick(1);
    int_pulse_i = '0;
  endtask

  task automatic sw_set(input logic [10:0] v);
    sw_set_i = v;
    tick(1);
    sw_set_i = '0;
  endtask

  task automatic sw_clr(input logic [10:0] v);
    sw_clr_i = v;
    tick(1);
    sw_clr_i = '0;
  endtask

  task automatic do_ack(input logic [3:0] ix);
    ack_i = 1'b1;
    ack_idx_i = ix;
    tick(1);
    ack_i = 1'b0;
    ack_idx_i = '0;
  endtask

  task automatic set_mask(input logic [10:0] v);
    mask_we_i = 1'b1;
    mask_d_i = v;
    tick(1);
    mask_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 idle after reset", 1'b0, 4'hF);
    glob_en_i = 1'b1;
    pulse_int(6);
    chk("R1 mask clear at reset", 1'b0, 4'hF);
    sw_clr(11'h7FF);
  endtask

  task automatic t_core_rst;
    core_rst_i = 1'b1;
    tick(1);
    chk("R2 reset request alone", 1'b1, 4'd0);
    sw_set(11'h001);
    chk("R2 reset over power-down", 1'b1, 4'd0);
    core_rst_i = 1'b0;
    tick(1);
    chk("R4 power-down unmasked", 1'b1, 4'd1);
    sw_clr(11'h001);
    chk("R11 sw clear", 1'b0, 4'hF);
  endtask

  task automatic t_internal;
    set_mask(11'h7FF);
    pulse_int(6);
    chk("R9 timer latched", 1'b1, 4'd11);
    tick(2);
    chk("R9 timer held", 1'b1, 4'd11);
    do_ack(4'd11);
    chk("R10 ack timer", 1'b0, 4'hF);
    pulse_int(3);
    chk("R9 dma latched", 1'b1, 4'd8);
    do_ack(4'd8);
  endtask

  task automatic t_priority;
    sw_set(11'b100_1001_0000);
    chk("R3 lowest slot wins", 1'b1, 4'd5);
    do_ack(4'd5);
    chk("R3 next slot", 1'b1, 4'd8);
    do_ack(4'd8);
    chk("R3 last slot", 1'b1, 4'd11);
    do_ack(4'd11);
    chk("R3 all served", 1'b0, 4'hF);
  endtask

  task automatic t_mask;
    sw_set(11'h010);
    set_mask(11'h7EF);
    chk("R12 slot4 masked", 1'b0, 4'hF);
    set_mask(11'h010);
    chk("R12 slot4 enabled", 1'b1, 4'd5);
    glob_en_i = 1'b0;
    tick(1);
    chk("R4 global disable", 1'b0, 4'hF);
    set_mask(11'h000);
    pulse_int(0);
    chk("R4 power-down ignores masks", 1'b1, 4'd1);
    sw_clr(11'h7FF);
    glob_en_i = 1'b1;
    set_mask(11'h7FF);
  endtask

  task automatic t_level;
    ext_n_i[1] = 1'b0;
    tick(1);
    chk("R5 level after one edge", 1'b0, 4'hF);
    tick(1);
    chk("R5 level after two edges", 1'b1, 4'd3);
    do_ack(4'd3);
    chk("R5 ack keeps level", 1'b1, 4'd3);
    ext_n_i[1] = 1'b1;
    tick(2);
    chk("R5 level released", 1'b0, 4'hF);
  endtask

  task automatic t_edge;
    ext_n_i[3] = 1'b0;
    tick(2);
    chk("R6 edge not yet", 1'b0, 4'hF);
    tick(1);
    chk("R6 edge latched", 1'b1, 4'd7);
    do_ack(4'd7);
    tick(3);
    chk("R6 held low no refire", 1'b0, 4'hF);
    ext_n_i[3] = 1'b1;
    tick(3);
    chk("R6 rise no event", 1'b0, 4'hF);
    ext_n_i[3] = 1'b0;
    tick(3);
    ext_n_i[3] = 1'b1;
    tick(3);
    chk("R6 sticky after rise", 1'b1, 4'd7);
    do_ack(4'd7);
  endtask

  task automatic t_prog;
    edge_sel_i[0] = 1'b0;
    ext_n_i[0] = 1'b0;
    tick(2);
    chk("R7 level mode", 1'b1, 4'd2);
    ext_n_i[0] = 1'b1;
    tick(2);
    chk("R7 level mode release", 1'b0, 4'hF);
    edge_sel_i[0] = 1'b1;
    ext_n_i[0] = 1'b0;
    tick(3);
    ext_n_i[0] = 1'b1;
    tick(3);
    chk("R7 edge mode latched", 1'b1, 4'd2);
    do_ack(4'd2);
    chk("R7 edge mode ack", 1'b0, 4'hF);
  endtask

  task automatic t_alt;
    ext_n_i[4] = 1'b0;
    tick(4);
    chk("R8 pin ignored when alt=0", 1'b0, 4'hF);
    ext_n_i[4] = 1'b1;
    tick(3);
    pulse_int(4);
    chk("R8 ser1 pulse when alt=0", 1'b1, 4'd9);
    do_ack(4'd9);
    alt_mode_i = 1'b1;
    edge_sel_i[1] = 1'b0;
    ext_n_i[4] = 1'b0;
    tick(2);
    chk("R8 pin level when alt=1", 1'b1, 4'd9);
    ext_n_i[4] = 1'b1;
    tick(2);
    pulse_int(4);
    pulse_int(5);
    chk("R8 pulses ignored when alt=1", 1'b0, 4'hF);
    edge_sel_i[2] = 1'b1;
    ext_n_i[5] = 1'b0;
    tick(3);
    chk("R8 pin edge when alt=1", 1'b1, 4'd10);
    ext_n_i[5] = 1'b1;
    do_ack(4'd10);
    tick(3);
    chk("R8 pin edge acked", 1'b0, 4'hF);
    alt_mode_i = 1'b0;
  endtask

  task automatic t_ack_bad;
    sw_set(11'h400);
    do_ack(4'd0);
    chk("R10 ack index 0 ignored", 1'b1, 4'd11);
    do_ack(4'd15);
    chk("R10 ack index 15 ignored", 1'b1, 4'd11);
    do_ack(4'd12);
    chk("R10 ack index 12 ignored", 1'b1, 4'd11);
    do_ack(4'd11);
    chk("R10 ack index 11", 1'b0, 4'hF);
  endtask

  task automatic t_sw;
    sw_set_i = 11'h040;
    sw_clr_i = 11'h040;
    tick(1);
    sw_set_i = '0;
    sw_clr_i = '0;
    chk("R11 set beats clear", 1'b1, 4'd7);
    sw_clr(11'h040);
    chk("R11 clear alone", 1'b0, 4'hF);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_core_rst();
    t_internal();
    t_priority();
    t_mask();
    t_level();
    t_edge();
    t_prog();
    t_alt();
    t_ack_bad();
    t_sw();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule